// File: doc/BRIEF.md
# Write-Status Polling Read Responder

This block forms the read-data path of a byte-wide nonvolatile memory model. It watches the active-low chip-select and read-enable strobes and decides what to place on the data bus. While no internal programming cycle is running, a read returns the word the array supplies for the current address. While a programming cycle is running, every read returns a status word instead. In that word the top bit is the inverse of the top bit of the last byte written, the next bit flips once per finished read access, and the lower bits are zero.

Host software detects the end of a write cycle in two ways. It can read repeatedly until the top bit matches the data it wrote. It can also read twice and compare the second-highest bit, which stops changing once programming ends. Neither method needs an extra pin. The block registers the bus value and its drive enable, so both settle one clock after the strobes are sampled. When the bus is not driven, the data output is held at zero.

Top module: `write_poll_resp`

## Requirements
- R1: `dataOutEn` is 1 in the cycle after a clock edge that samples both `chipEnN` and `outEnN` low. It is 0 after any edge that samples either strobe high.
- R2: While `dataOutEn` is 0, `dataOut` is all zeros.
- R3: When `busy` is 0 at the sampling edge, a read returns `arrayData` as sampled at that edge, one cycle later.
- R4: When `busy` is 1 at the sampling edge, bit DATA_W-1 (bit 7 at the default width) of the returned word is the complement of `lastWrMsb`.
- R5: When `busy` is 1, bits DATA_W-3..0 (bits 5..0 at the default width) of the returned word are 0.
- R6: When `busy` is 1, bit DATA_W-2 (bit 6 at the default width) holds a toggle state. That state inverts when a read access ends, meaning the first edge that samples a strobe high after an edge that sampled both low, provided `busy` is 1 at that edge. It does not change during a continuous access.
- R7: An access that ends while `busy` is 0 leaves the toggle state unchanged, as does a strobe pattern that never makes an access. The next busy read continues from the held value.
- R8: After reset, `dataOutEn` is 0, `dataOut` is 0 and the toggle state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEnN | input | 1 | Chip select, active low |
| outEnN | input | 1 | Read enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| lastWrMsb | input | 1 | Top bit of the last byte written |
| arrayData | input | DATA_W | Stored word for the current address |
| dataOut | output | DATA_W | Registered read data |
| dataOutEn | output | 1 | Registered bus drive enable (tri-state control) |

## Verification
A wrong toggle state only shows up on bit 6 of a busy read. The error therefore stays hidden until the first busy read after the corrupting event. That read shows the wrong level one cycle after its sampling edge. A missed or extra access-end detection appears as two equal, or two differing, bit-6 values within one busy read or across two busy reads. A fault in output selection appears on the very first read after the wrong choice, as array data in place of status or the reverse. A fault in the enable appears as a driven or undriven bus one cycle after the strobes change.

// File: rtl/write_poll_resp_pkg.sv
package write_poll_resp_pkg;
  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic drive;       // a read access is sampled this edge
    logic pickStatus;  // return the status word instead of array data
    logic flipToggle;  // an access ended while programming is running
  } respCmd_t;
endpackage

// File: rtl/write_poll_resp_ctrl.sv
module write_poll_resp_ctrl
  import write_poll_resp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     chipEnN,
  input  logic     outEnN,
  input  logic     busy,
  output respCmd_t cmd
);
  logic accessNow;
  logic accessPrev;

  assign accessNow = !chipEnN && !outEnN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accessPrev <= 1'b0;
    else       accessPrev <= accessNow;
  end

  always_comb begin
    cmd.drive      = accessNow;
    cmd.pickStatus = busy;
    cmd.flipToggle = accessPrev && !accessNow && busy;
  end
endmodule

// File: rtl/write_poll_resp_dp.sv
module write_poll_resp_dp
  import write_poll_resp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  respCmd_t          cmd,
  input  logic              lastWrMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int RSVD_W = DATA_W - 2;

  logic              toggleQ;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] nextWord;

  assign statusWord = {~lastWrMsb, toggleQ, {RSVD_W{1'b0}}};

  always_comb begin
    if (!cmd.drive)          nextWord = '0;
    else if (cmd.pickStatus) nextWord = statusWord;
    else                     nextWord = arrayData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ   <= 1'b0;
      dataOut   <= '0;
      dataOutEn <= 1'b0;
    end else begin
      if (cmd.flipToggle) toggleQ <= ~toggleQ;
      dataOut   <= nextWord;
      dataOutEn <= cmd.drive;
    end
  end
endmodule

// File: rtl/write_poll_resp.sv
module write_poll_resp
  import write_poll_resp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              busy,
  input  logic              lastWrMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  respCmd_t cmd;

  write_poll_resp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .busy(busy), .cmd(cmd)
  );

  write_poll_resp_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lastWrMsb(lastWrMsb),
    .arrayData(arrayData), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/write_poll_resp_chk.sv
module write_poll_resp_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEnN,
  input logic              outEnN,
  input logic              busy,
  input logic              lastWrMsb,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn
);
  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !outEnN) |=> dataOutEn); // R1
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (chipEnN || outEnN) |=> !dataOutEn); // R1
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> dataOut == '0); // R2
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !chipEnN && !outEnN) |=> dataOut == $past(arrayData)); // R3
  AST_POLL_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !chipEnN && !outEnN) |=> dataOut[DATA_W-1] == ~$past(lastWrMsb)); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !chipEnN && !outEnN) |=> dataOut[DATA_W-3:0] == '0); // R5
  AST_TOGGLE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !chipEnN && !outEnN && dataOutEn)
      |=> dataOut[DATA_W-2] == $past(dataOut[DATA_W-2])); // R6
endmodule

bind write_poll_resp write_poll_resp_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .busy(busy),
  .lastWrMsb(lastWrMsb), .arrayData(arrayData), .dataOut(dataOut),
  .dataOutEn(dataOutEn)
);

// File: tb/test_write_poll_resp.sv
module test_write_poll_resp;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         chipEnN = 1'b1;
  logic         outEnN = 1'b1;
  logic         busy = 1'b0;
  logic         lastWrMsb = 1'b0;
  logic [W-1:0] arrayData = '0;
  logic [W-1:0] dataOut;
  logic         dataOutEn;

  int  checks = 0;
  int  errors = 0;
  logic expTog = 1'b0;

  always #2 clk = ~clk;

  write_poll_resp #(.DATA_W(W)) i_write_poll_resp (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .busy(busy),
    .lastWrMsb(lastWrMsb), .arrayData(arrayData), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  task automatic chk(input logic [W:0] act, input logic [W:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] statusOf(input logic msb, input logic tog);
    return {~msb, tog, 6'b0};
  endfunction

  // one read access of 'len' cycles; ends by raising chip enable or output enable
  task automatic readOnce(input logic [W-1:0] arr, input logic msb, input logic bsy,
                          input int len, input logic endByCe);
    logic [W-1:0] exp;
    chipEnN = 1'b0; outEnN = 1'b0; arrayData = arr; lastWrMsb = msb; busy = bsy;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      exp = bsy ? statusOf(msb, expTog) : arr;
      chk({dataOutEn, dataOut}, {1'b1, exp}, bsy ? "R4 R5 R6 busy read" : "R1 R3 idle read");
    end
    if (endByCe) chipEnN = 1'b1; else outEnN = 1'b1;
    @(negedge clk);
    if (bsy) expTog = ~expTog;
    chk({dataOutEn, dataOut}, {1'b0, {W{1'b0}}}, "R1 R2 bus released");
    chipEnN = 1'b1; outEnN = 1'b1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk({dataOutEn, dataOut}, '0, "R8 reset state");
    rstN = 1'b1;
    @(negedge clk);
    chk({dataOutEn, dataOut}, '0, "R8 idle after reset");

    // R3: idle sweep over every array word
    for (int v = 0; v < 256; v++) readOnce(W'(v), v[0], 1'b0, 1, v[1]);

    // R4 R5 R6: busy sweep, toggle starts at reset value 0
    for (int v = 0; v < 256; v++) readOnce(W'(v), v[2], 1'b1, 1, v[0]);

    // R6: long accesses keep bit 6 steady within the access
    readOnce(8'h5A, 1'b0, 1'b1, 4, 1'b0);
    readOnce(8'hA5, 1'b1, 1'b1, 3, 1'b1);

    // R7 R1: partial strobes never drive the bus or move the toggle
    busy = 1'b1;
    chipEnN = 1'b0; outEnN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({dataOutEn, dataOut}, '0, "R1 R7 chip select only");
    chipEnN = 1'b1; outEnN = 1'b0;
    @(negedge clk); @(negedge clk);
    chk({dataOutEn, dataOut}, '0, "R1 R7 read enable only");
    outEnN = 1'b1;
    readOnce(8'h00, 1'b0, 1'b1, 1, 1'b0);

    // R7: idle reads keep the toggle, busy resumes from held value
    for (int v = 0; v < 5; v++) readOnce(W'(8'h30 + v), 1'b1, 1'b0, 2, 1'b0);
    readOnce(8'hFF, 1'b1, 1'b1, 1, 1'b1);
    readOnce(8'h11, 1'b0, 1'b1, 1, 1'b0);

    // R3: after busy drops, stored data returns
    readOnce(8'hC3, 1'b0, 1'b0, 2, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule